// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the host write port of a flash emulator and turns the stream of bus write cycles into flash commands. It follows the protected command protocol, in which a fixed unlock pattern must come before every command that alters the array. A program needs three command writes followed by a data write. Any erase needs six command writes. Two further sequences switch the emulator into identification mode or query-table mode, and a single exit write returns it to plain reads.

The decoder checks every write against exactly one expected cycle. Any write that does not match drops the sequence and returns the block to read mode. Only the low byte of the data bus takes part in command matching. Protection cannot be turned off. While the array model reports an operation in progress on `busy_i`, every write is ignored.

Decoded program and erase commands appear as single-cycle strobes with their address and data. Identification and query mode are level outputs that the read path uses to select its data source.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset no strobe is high, `id_mode` and `query_mode` are 0, and the first write is matched as the start of a sequence.
- R2: The writes low byte AAh at 5555h, then 55h at 2AAAh, then A0h at 5555h, then a data write to any address give a `pgm_stb` pulse one cycle long. It rises in the cycle after the data write. `pgm_addr` and the full 16-bit `pgm_data` hold that write's address and data.
- R3: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh are followed by a sixth write. A sixth write of 10h@5555h gives `ers_chip_stb`. A sixth write of 30h at any address gives `ers_sector_stb`, and 50h at any address gives `ers_block_stb`. Each strobe is one cycle long, and `ers_addr` holds the sixth write's address.
- R4: AAh@5555h, 55h@2AAAh, 90h@5555h sets `id_mode`. The same unlock pair followed by 98h@5555h sets `query_mode`. The two flags are never high together.
- R5: In ID or query mode, a write whose low byte is F0h returns the block to read mode, whatever its address. Every other write in those modes is ignored: it gives no strobe and does not change the mode.
- R6: A write that does not match the next expected cycle ends the sequence with no strobe. That write does not count as the start of a new sequence, and a complete sequence afterwards decodes normally.
- R7: Command matching compares only data bits 7:0. Bits 15:8 may hold any value.
- R8: While `busy_i` is 1, writes are ignored. The sequence position and the mode are both held, so a sequence interrupted by busy continues once busy clears.
- R9: At most one strobe is high in any cycle, and a strobe never lasts two cycles.
- R10: Unlock and command addresses are compared on all 16 bits. A near-miss address such as 2AABh aborts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 16 | Write address |
| wr_data | input | 16 | Write data |
| busy_i | input | 1 | Array operation in progress; writes are ignored |
| pgm_stb | output | 1 | Program command pulse |
| pgm_addr | output | 16 | Program address |
| pgm_data | output | 16 | Program data |
| ers_sector_stb | output | 1 | Sector erase pulse |
| ers_block_stb | output | 1 | Block erase pulse |
| ers_chip_stb | output | 1 | Chip erase pulse |
| ers_addr | output | 16 | Erase address |
| id_mode | output | 1 | Identification mode flag |
| query_mode | output | 1 | Query-table mode flag |

## Verification
The bench targets the following corner cases:
- An abort whose own write happens to be a legal first cycle. A decoder that re-arms on that write would emit a program from a shortened sequence.
- An erase broken at its fourth cycle by an address one off. A decoder that compares only part of the address, or that skips the second unlock pair, would still erase.
- Unlock bytes carrying garbage in the upper byte. A design that compares all 16 bits would never decode, while the program data must still keep its upper byte.
- A sequence paused by busy in its middle, plus a full program sequence sent while in ID mode. These show whether busy and the ID or query mode really freeze the decoder and keep it from firing strobes.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PGM, S_ERS3, S_ERS4, S_ERS5
  } seq_e;

  typedef enum logic [1:0] {M_READ, M_ID, M_QUERY} mode_e;

  localparam logic [7:0] C_UNL1  = 8'hAA;
  localparam logic [7:0] C_UNL2  = 8'h55;
  localparam logic [7:0] C_PGM   = 8'hA0;
  localparam logic [7:0] C_ERS   = 8'h80;
  localparam logic [7:0] C_ID    = 8'h90;
  localparam logic [7:0] C_QRY   = 8'h98;
  localparam logic [7:0] C_CHIP  = 8'h10;
  localparam logic [7:0] C_SECT  = 8'h30;
  localparam logic [7:0] C_BLK   = 8'h50;
  localparam logic [7:0] C_EXIT  = 8'hF0;

  // classification of one write cycle
  typedef struct packed {
    logic unl1;
    logic unl2;
    logic pgm;
    logic ers;
    logic id;
    logic qry;
    logic chip;
    logic sect;
    logic blk;
    logic quit;
  } cyc_t;

  function automatic logic code_hit(input logic [7:0] lo, input logic [7:0] code);
    return lo == code;
  endfunction

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W = 16,
  parameter int          CMD_W  = 8,
  parameter logic [15:0] ADR_A  = 16'h5555,
  parameter logic [15:0] ADR_B  = 16'h2AAA
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CMD_W-1:0]  code,
  output cyc_t              cyc
);
  localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(ADR_A);
  localparam logic [ADDR_W-1:0] B_KEY = ADDR_W'(ADR_B);

  logic at_a, at_b;
  logic [7:0] lo;

  always_comb begin
    at_a = (addr == A_KEY);
    at_b = (addr == B_KEY);
    lo   = 8'(code);
    cyc.unl1 = at_a & code_hit(lo, C_UNL1);
    cyc.unl2 = at_b & code_hit(lo, C_UNL2);
    cyc.pgm  = at_a & code_hit(lo, C_PGM);
    cyc.ers  = at_a & code_hit(lo, C_ERS);
    cyc.id   = at_a & code_hit(lo, C_ID);
    cyc.qry  = at_a & code_hit(lo, C_QRY);
    cyc.chip = at_a & code_hit(lo, C_CHIP);
    cyc.sect = code_hit(lo, C_SECT);
    cyc.blk  = code_hit(lo, C_BLK);
    cyc.quit = code_hit(lo, C_EXIT);
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  cyc_t              cyc,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              pgm_stb,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [DATA_W-1:0] pgm_data,
  output logic              sect_stb,
  output logic              blk_stb,
  output logic              chip_stb,
  output logic [ADDR_W-1:0] ers_addr,
  output mode_e             mode
);
  seq_e  state, state_n;
  mode_e mode_n;
  logic  do_pgm, do_sect, do_blk, do_chip;

  always_comb begin
    state_n = state;
    mode_n  = mode;
    do_pgm  = 1'b0;
    do_sect = 1'b0;
    do_blk  = 1'b0;
    do_chip = 1'b0;
    if (fire) begin
      if (mode != M_READ) begin
        state_n = S_IDLE;
        if (cyc.quit) mode_n = M_READ;
      end else begin
        unique case (state)
          S_IDLE: state_n = cyc.unl1 ? S_UNL1 : S_IDLE;
          S_UNL1: state_n = cyc.unl2 ? S_UNL2 : S_IDLE;
          S_UNL2: begin
            state_n = S_IDLE;
            if (cyc.pgm)      state_n = S_PGM;
            else if (cyc.ers) state_n = S_ERS3;
            else if (cyc.id)  mode_n  = M_ID;
            else if (cyc.qry) mode_n  = M_QUERY;
          end
          S_PGM: begin
            do_pgm  = 1'b1;
            state_n = S_IDLE;
          end
          S_ERS3: state_n = cyc.unl1 ? S_ERS4 : S_IDLE;
          S_ERS4: state_n = cyc.unl2 ? S_ERS5 : S_IDLE;
          S_ERS5: begin
            do_chip = cyc.chip;
            do_sect = cyc.sect;
            do_blk  = cyc.blk;
            state_n = S_IDLE;
          end
          default: state_n = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      mode     <= M_READ;
      pgm_stb  <= 1'b0;
      sect_stb <= 1'b0;
      blk_stb  <= 1'b0;
      chip_stb <= 1'b0;
      pgm_addr <= '0;
      pgm_data <= '0;
      ers_addr <= '0;
    end else begin
      state    <= state_n;
      mode     <= mode_n;
      pgm_stb  <= do_pgm;
      sect_stb <= do_sect;
      blk_stb  <= do_blk;
      chip_stb <= do_chip;
      if (do_pgm) begin
        pgm_addr <= addr;
        pgm_data <= data;
      end
      if (do_sect | do_blk | do_chip) ers_addr <= addr;
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CMD_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy_i,
  output logic              pgm_stb,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [DATA_W-1:0] pgm_data,
  output logic              ers_sector_stb,
  output logic              ers_block_stb,
  output logic              ers_chip_stb,
  output logic [ADDR_W-1:0] ers_addr,
  output logic              id_mode,
  output logic              query_mode
);
  cyc_t  cyc;
  mode_e mode;
  logic  wr_accept;

  assign wr_accept = wr_en & ~busy_i;

  flash_cmd_match #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_match (
    .addr (wr_addr),
    .code (wr_data[CMD_W-1:0]),
    .cyc  (cyc)
  );

  flash_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (wr_accept),
    .cyc      (cyc),
    .addr     (wr_addr),
    .data     (wr_data),
    .pgm_stb  (pgm_stb),
    .pgm_addr (pgm_addr),
    .pgm_data (pgm_data),
    .sect_stb (ers_sector_stb),
    .blk_stb  (ers_block_stb),
    .chip_stb (ers_chip_stb),
    .ers_addr (ers_addr),
    .mode     (mode)
  );

  assign id_mode    = (mode == M_ID);
  assign query_mode = (mode == M_QUERY);
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_accept,
  input logic              busy_i,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              pgm_stb,
  input logic              ers_sector_stb,
  input logic              ers_block_stb,
  input logic              ers_chip_stb,
  input logic              id_mode,
  input logic              query_mode
);
  logic any_stb;
  assign any_stb = pgm_stb | ers_sector_stb | ers_block_stb | ers_chip_stb;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pgm_stb, ers_sector_stb, ers_block_stb, ers_chip_stb})); // R9

  AST_STROBE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |=> !any_stb); // R9

  AST_STROBE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> $past(wr_en && !busy_i && wr_accept)); // R8

  AST_BUSY_HOLDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(id_mode) && $stable(query_mode))); // R8

  AST_MODES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(id_mode && query_mode)); // R4

  AST_NO_STROBE_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (id_mode || query_mode) |=> !any_stb); // R5

  AST_QUERY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(query_mode) |-> $past(wr_en && wr_addr == 16'h5555 && wr_data[7:0] == 8'h98)); // R4

  AST_QUERY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(query_mode) |-> $past(wr_en && wr_data[7:0] == 8'hF0)); // R5

  AST_ID_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(id_mode) |-> $past(wr_en && wr_data[7:0] == 8'hF0)); // R5
endmodule

bind flash_cmd_decoder flash_cmd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_en          (wr_en),
  .wr_accept      (wr_accept),
  .busy_i         (busy_i),
  .wr_addr        (wr_addr),
  .wr_data        (wr_data),
  .pgm_stb        (pgm_stb),
  .ers_sector_stb (ers_sector_stb),
  .ers_block_stb  (ers_block_stb),
  .ers_chip_stb   (ers_chip_stb),
  .id_mode        (id_mode),
  .query_mode     (query_mode)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy_i = 1'b0;
  logic        pgm_stb, ers_sector_stb, ers_block_stb, ers_chip_stb;
  logic [15:0] pgm_addr, pgm_data, ers_addr;
  logic        id_mode, query_mode;

  int n_chk = 0;
  int n_bad = 0;

  // kind: 1 program, 2 sector, 3 block, 4 chip
  typedef struct {int kind; logic [15:0] addr; logic [15:0] data; string req;} item_t;
  item_t exp_q[$];

  always #5 clk = ~clk;

  flash_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy_i(busy_i), .pgm_stb(pgm_stb), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .ers_sector_stb(ers_sector_stb), .ers_block_stb(ers_block_stb),
    .ers_chip_stb(ers_chip_stb), .ers_addr(ers_addr),
    .id_mode(id_mode), .query_mode(query_mode)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock(input logic [15:0] hi);
    wr(16'h5555, hi | 16'h00AA);
    wr(16'h2AAA, hi | 16'h0055);
  endtask

  task automatic expect_item(input int k, input logic [15:0] a, input logic [15:0] d, input string r);
    item_t it;
    it.kind = k; it.addr = a; it.data = d; it.req = r;
    exp_q.push_back(it);
  endtask

  task automatic program_word(input logic [15:0] a, input logic [15:0] d, input logic [15:0] hi,
                              input bit expect_it, input string r);
    unlock(hi);
    wr(16'h5555, hi | 16'h00A0);
    if (expect_it) expect_item(1, a, d, r);
    wr(a, d);
  endtask

  task automatic erase(input logic [15:0] a, input logic [7:0] code, input int k, input string r);
    unlock(16'h0000);
    wr(16'h5555, 16'h0080);
    unlock(16'h0000);
    expect_item(k, a, 16'h0000, r);
    wr(a, {8'h00, code});
  endtask

  // monitor: pops expected items as strobes appear
  always @(negedge clk) begin
    if (rst_n && (pgm_stb | ers_sector_stb | ers_block_stb | ers_chip_stb)) begin
      int k;
      logic [15:0] a, d;
      k = 0;
      a = pgm_stb ? pgm_addr : ers_addr;
      d = pgm_stb ? pgm_data : 16'h0000;
      k = pgm_stb + 2 * ers_sector_stb + 3 * ers_block_stb + 4 * ers_chip_stb;
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected strobe", k, 0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check(k == it.kind, {it.req, " kind"}, k, it.kind);
        check(a == it.addr, {it.req, " addr"}, a, it.addr);
        check(d == it.data, {it.req, " data"}, d, it.data);
      end
    end
  end

  initial begin
    #1_000_000;
    check(1'b0, "watchdog", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!id_mode && !query_mode, "R1 mode after reset", {id_mode, query_mode}, 0);
    check(!(pgm_stb | ers_sector_stb | ers_block_stb | ers_chip_stb), "R1 strobes idle", pgm_stb, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 program, R1 first write starts sequence
    program_word(16'h1234, 16'hBEEF, 16'h0000, 1'b1, "R2 program");
    // R7 upper byte garbage on command cycles, full data kept
    program_word(16'hF00D, 16'hA5A5, 16'hC300, 1'b1, "R7 upper byte ignored");
    // R3 erase variants
    erase(16'h5555, 8'h10, 4, "R3 chip erase");
    erase(16'h4000, 8'h30, 2, "R3 sector erase");
    erase(16'h8000, 8'h50, 3, "R3 block erase");

    // R6 abort on bad third cycle; the abort write AA@5555 must not re-arm
    unlock(16'h0000);
    wr(16'h5555, 16'h00AA);
    wr(16'h2AAA, 16'h0055);
    wr(16'h5555, 16'h00A0);
    wr(16'h0100, 16'h0042);
    check(!id_mode && !query_mode, "R6 read mode after abort", id_mode, 0);
    program_word(16'h0200, 16'h0777, 16'h0000, 1'b1, "R6 recovery program");

    // R10 erase broken at fourth cycle by near-miss address
    unlock(16'h0000);
    wr(16'h5555, 16'h0080);
    wr(16'h5554, 16'h00AA);
    wr(16'h2AAA, 16'h0055);
    wr(16'h5555, 16'h0010);
    // R10 near-miss on second unlock
    wr(16'h5555, 16'h00AA);
    wr(16'h2AAB, 16'h0055);
    wr(16'h5555, 16'h00A0);
    wr(16'h0300, 16'h1111);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R10 no strobe from near miss", exp_q.size(), 0);

    // R4 ID entry, R5 writes ignored in ID mode
    unlock(16'h0000);
    wr(16'h5555, 16'h0090);
    check(id_mode && !query_mode, "R4 id entry", {id_mode, query_mode}, 2);
    program_word(16'h0400, 16'h2222, 16'h0000, 1'b0, "R5");
    check(id_mode, "R5 id held by other writes", id_mode, 1);
    wr(16'h0123, 16'h00F0);
    check(!id_mode && !query_mode, "R5 id exit", {id_mode, query_mode}, 0);

    // R4 query entry, R5 exit with upper byte set
    unlock(16'h0000);
    wr(16'h5555, 16'h0098);
    check(query_mode && !id_mode, "R4 query entry", {id_mode, query_mode}, 1);
    wr(16'hABCD, 16'h7FF0);
    check(!query_mode, "R5 query exit", query_mode, 0);

    // R8 full sequence under busy is ignored
    busy_i = 1'b1;
    program_word(16'h0500, 16'h3333, 16'h0000, 1'b0, "R8");
    unlock(16'h0000);
    wr(16'h5555, 16'h0098);
    check(!query_mode, "R8 busy blocks query entry", query_mode, 0);
    busy_i = 1'b0;
    // R8 sequence paused by busy continues afterwards
    unlock(16'h0000);
    busy_i = 1'b1;
    wr(16'h0000, 16'h0000);
    busy_i = 1'b0;
    wr(16'h5555, 16'h00A0);
    expect_item(1, 16'h0600, 16'h4444, "R8 resumed program");
    wr(16'h0600, 16'h4444);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R9 all expected strobes seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule